// File: doc/BRIEF.md
# Host-to-Controller Mailbox Channel

This block is one byte-wide mailbox between a host bus and an embedded controller core. The host side sees two ports: a data port at offset 0 and a command/status port at offset 4. A host write to either port fills the input buffer and records which port was used. A host read of offset 0 returns the output buffer. A host read of offset 4 returns the status byte. The core side is a small register file. It can read the input buffer, write the output buffer in three ways (plain, with an SCI pulse, with an SMI pulse), set its own status flags and enable an interrupt.

The buffer-full flags are held by two instances of a two-state machine. The states are `FLAG_EMPTY` and `FLAG_FULL`. The named transitions are:
- SET: `FLAG_EMPTY` to `FLAG_FULL`, on a load.
- DRAIN: `FLAG_FULL` to `FLAG_EMPTY`, on a consuming read with no load in the same cycle.
- REFILL: `FLAG_FULL` to `FLAG_FULL`, on a load while already full.

In each machine, a load takes priority over a drain in the same cycle.

In ACPI use, status flag ST0 reports burst mode, ST1 reports a pending SCI event and ST2 reports a pending SMI event. Firmware drives these three flags through the core status register.

Top module: `mbox_channel`

## Requirements
- R1: After reset, the status byte is 0x00, both pulse outputs are low, `c_irq` is low and the interrupt enable is 0.
- R2: The status byte has this layout: bit 0 is output-full (OBF), bit 1 is input-full (IBF), bit 2 is F0, bit 3 is A2 and bits 7:4 are ST3..ST0, with ST0 at bit 4. The host reads it at host offset 4, and the core reads it at core offset 0.
- R3: A core write to core offset 1, 2 or 3 loads the output buffer and sets OBF. A host read strobe at host offset 0 returns the buffer and clears OBF. If a load and a host read fall in the same cycle, OBF stays set.
- R4: A host write to offset 0 or offset 4 loads the input buffer and sets IBF. A core read strobe at core offset 4 or 5 returns the buffer and clears IBF. If a host write and a core read fall in the same cycle, IBF stays set.
- R5: A2 becomes 0 after a host write to offset 0 and 1 after a host write to offset 4. A2 keeps its value through core reads.
- R6: A core write to core offset 0 changes only F0 (from data bit 2) and ST3..ST0 (from data bits 7:4). Data bits 0, 1 and 3 are ignored.
- R7: A core write to offset 2 drives `h_sci` high for exactly the next cycle. A core write to offset 3 does the same for `h_smi`. A write to offset 1 raises neither output.
- R8: `c_irq` equals IBF AND the enable bit, where the enable bit is core offset 6, bit 0. It drops once the core read drains IBF.
- R9: A host write while IBF is already set replaces the buffered byte, and IBF stays set.
- R10: Host writes to offsets other than 0 and 4 change nothing. Host reads at those offsets return 0x00, as do core reads at unused core offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | HADDR_W | Host offset (0 data, 4 command/status) |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (consumes output data at offset 0) |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte, combinational from `h_addr` |
| h_sci | output | 1 | One-cycle SCI event toward the host |
| h_smi | output | 1 | One-cycle SMI event toward the host |
| c_addr | input | CADDR_W | Core register offset |
| c_wr | input | 1 | Core write strobe |
| c_rd | input | 1 | Core read strobe (consumes input data at 4/5) |
| c_wdata | input | 8 | Core write byte |
| c_rdata | output | 8 | Core read byte, combinational from `c_addr` |
| c_irq | output | 1 | Input-full interrupt request to the core |

## Verification
The traffic is checked against the reference model on every clock. The sequences cover a data-port write and a command-port write, each followed by a drain, which separates the A2 values and shows that A2 survives the drain. A write into a full input buffer separates overwrite from drop. Collisions in the same cycle (host write with core read, and core load with host read) show that a load takes priority over a drain. The three data-out variants are told apart by which pulse appears, if any. A status write of all ones shows that the read-only bits ignore it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int BYTE_W = 8;

    // host offsets
    localparam int HOST_DATA_OFS = 0;
    localparam int HOST_CMD_OFS  = 4;

    // core register offsets
    localparam int CREG_STAT     = 0;
    localparam int CREG_DOUT     = 1;
    localparam int CREG_DOUT_SCI = 2;
    localparam int CREG_DOUT_SMI = 3;
    localparam int CREG_DIN      = 4;
    localparam int CREG_DIN_ALT  = 5;
    localparam int CREG_IEN      = 6;

    localparam int N_EVT   = 2;
    localparam int EVT_SCI = 0;
    localparam int EVT_SMI = 1;

    typedef enum logic {
        FLAG_EMPTY = 1'b0,
        FLAG_FULL  = 1'b1
    } flag_state_e;
endpackage

// File: rtl/mbox_flag_fsm.sv
module mbox_flag_fsm
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic drain,
    output logic full
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_EMPTY: if (load)       state_d = FLAG_FULL;   // SET
            FLAG_FULL:  if (load)       state_d = FLAG_FULL;   // REFILL
                        else if (drain) state_d = FLAG_EMPTY;  // DRAIN
        endcase
    end

    always_comb full = (state_q == FLAG_FULL);
endmodule

// File: rtl/mbox_host_evt.sv
module mbox_host_evt #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fire,
    output logic [N-1:0] pulse
);
    for (genvar g = 0; g < N; g++) begin : g_evt
        logic q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= fire[g];
        end
        assign pulse[g] = q;
    end
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel
    import mbox_pkg::*;
#(
    parameter int HADDR_W = 3,
    parameter int CADDR_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HADDR_W-1:0] h_addr,
    input  logic               h_wr,
    input  logic               h_rd,
    input  logic [7:0]         h_wdata,
    output logic [7:0]         h_rdata,
    output logic               h_sci,
    output logic               h_smi,
    input  logic [CADDR_W-1:0] c_addr,
    input  logic               c_wr,
    input  logic               c_rd,
    input  logic [7:0]         c_wdata,
    output logic [7:0]         c_rdata,
    output logic               c_irq
);
    localparam logic [HADDR_W-1:0] H_DATA = HADDR_W'(HOST_DATA_OFS);
    localparam logic [HADDR_W-1:0] H_CMD  = HADDR_W'(HOST_CMD_OFS);

    logic h_is_data, h_is_cmd, host_load, host_take;
    logic core_load, core_take;
    logic obf, ibf;
    logic [BYTE_W-1:0] din_q, dout_q, status;
    logic a2_q, f0_q, ien_q;
    logic [3:0] st_q;
    logic [N_EVT-1:0] evt_fire, evt_pulse;

    always_comb begin
        h_is_data = (h_addr == H_DATA);
        h_is_cmd  = (h_addr == H_CMD);
        host_load = h_wr && (h_is_data || h_is_cmd);
        host_take = h_rd && h_is_data;
        core_load = c_wr && ((c_addr == CADDR_W'(CREG_DOUT))
                          || (c_addr == CADDR_W'(CREG_DOUT_SCI))
                          || (c_addr == CADDR_W'(CREG_DOUT_SMI)));
        core_take = c_rd && ((c_addr == CADDR_W'(CREG_DIN))
                          || (c_addr == CADDR_W'(CREG_DIN_ALT)));
    end

    mbox_flag_fsm u_ibf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (host_load),
        .drain (core_take),
        .full  (ibf)
    );

    mbox_flag_fsm u_obf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (core_load),
        .drain (host_take),
        .full  (obf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            din_q  <= '0;
            dout_q <= '0;
            a2_q   <= 1'b0;
            f0_q   <= 1'b0;
            st_q   <= '0;
            ien_q  <= 1'b0;
        end else begin
            if (host_load) begin
                din_q <= h_wdata;
                a2_q  <= h_is_cmd;
            end
            if (core_load) dout_q <= c_wdata;
            if (c_wr && (c_addr == CADDR_W'(CREG_STAT))) begin
                f0_q <= c_wdata[2];
                st_q <= c_wdata[7:4];
            end
            if (c_wr && (c_addr == CADDR_W'(CREG_IEN))) ien_q <= c_wdata[0];
        end
    end

    always_comb status = {st_q, a2_q, f0_q, ibf, obf};

    always_comb begin
        if (h_is_data)     h_rdata = dout_q;
        else if (h_is_cmd) h_rdata = status;
        else               h_rdata = '0;
    end

    always_comb begin
        unique case (int'(c_addr))
            CREG_STAT:              c_rdata = status;
            CREG_DIN, CREG_DIN_ALT: c_rdata = din_q;
            CREG_IEN:               c_rdata = {7'd0, ien_q};
            default:                c_rdata = '0;
        endcase
    end

    always_comb begin
        evt_fire          = '0;
        evt_fire[EVT_SCI] = c_wr && (c_addr == CADDR_W'(CREG_DOUT_SCI));
        evt_fire[EVT_SMI] = c_wr && (c_addr == CADDR_W'(CREG_DOUT_SMI));
    end

    mbox_host_evt #(.N(N_EVT)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (evt_fire),
        .pulse (evt_pulse)
    );

    assign h_sci = evt_pulse[EVT_SCI];
    assign h_smi = evt_pulse[EVT_SMI];
    assign c_irq = ibf && ien_q;
endmodule

// File: rtl/mbox_channel_chk.sv
module mbox_channel_chk
    import mbox_pkg::*;
#(
    parameter int HADDR_W = 3,
    parameter int CADDR_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [HADDR_W-1:0] h_addr,
    input logic               h_wr,
    input logic               h_rd,
    input logic               h_sci,
    input logic               h_smi,
    input logic [CADDR_W-1:0] c_addr,
    input logic               c_wr,
    input logic               c_rd,
    input logic               c_irq,
    input logic               obf,
    input logic               ibf,
    input logic               a2_q
);
    logic hw_any, hw_cmd, hr_data, cw_load, cr_take, cw_sci, cw_smi;
    always_comb begin
        hw_any  = h_wr && (int'(h_addr) == HOST_DATA_OFS || int'(h_addr) == HOST_CMD_OFS);
        hw_cmd  = h_wr && (int'(h_addr) == HOST_CMD_OFS);
        hr_data = h_rd && (int'(h_addr) == HOST_DATA_OFS);
        cw_sci  = c_wr && (int'(c_addr) == CREG_DOUT_SCI);
        cw_smi  = c_wr && (int'(c_addr) == CREG_DOUT_SMI);
        cw_load = cw_sci || cw_smi || (c_wr && int'(c_addr) == CREG_DOUT);
        cr_take = c_rd && (int'(c_addr) == CREG_DIN || int'(c_addr) == CREG_DIN_ALT);
    end

    p_obf_load_r3:  assert property (@(posedge clk) disable iff (!rst_n) cw_load |=> obf);
    p_obf_drain_r3: assert property (@(posedge clk) disable iff (!rst_n) (hr_data && !cw_load) |=> !obf);
    p_ibf_load_r4:  assert property (@(posedge clk) disable iff (!rst_n) hw_any |=> ibf);
    p_ibf_drain_r4: assert property (@(posedge clk) disable iff (!rst_n) (cr_take && !hw_any) |=> !ibf);
    p_a2_cmd_r5:    assert property (@(posedge clk) disable iff (!rst_n) hw_cmd |=> a2_q);
    p_a2_hold_r5:   assert property (@(posedge clk) disable iff (!rst_n) !hw_any |=> $stable(a2_q));
    p_sci_fire_r7:  assert property (@(posedge clk) disable iff (!rst_n) cw_sci |=> h_sci);
    p_sci_src_r7:   assert property (@(posedge clk) disable iff (!rst_n) !cw_sci |=> !h_sci);
    p_smi_fire_r7:  assert property (@(posedge clk) disable iff (!rst_n) cw_smi |=> h_smi);
    p_smi_src_r7:   assert property (@(posedge clk) disable iff (!rst_n) !cw_smi |=> !h_smi);
    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n) (cr_take && !hw_any) |=> !c_irq);
endmodule

bind mbox_channel mbox_channel_chk #(.HADDR_W(HADDR_W), .CADDR_W(CADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .h_addr (h_addr),
    .h_wr   (h_wr),
    .h_rd   (h_rd),
    .h_sci  (h_sci),
    .h_smi  (h_smi),
    .c_addr (c_addr),
    .c_wr   (c_wr),
    .c_rd   (c_rd),
    .c_irq  (c_irq),
    .obf    (obf),
    .ibf    (ibf),
    .a2_q   (a2_q)
);

// File: tb/tb_mbox_channel.sv
module tb_mbox_channel;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] h_addr = '0;
    logic h_wr = 1'b0, h_rd = 1'b0;
    logic [7:0] h_wdata = '0;
    logic [7:0] h_rdata;
    logic h_sci, h_smi;
    logic [2:0] c_addr = '0;
    logic c_wr = 1'b0, c_rd = 1'b0;
    logic [7:0] c_wdata = '0;
    logic [7:0] c_rdata;
    logic c_irq;

    int checks = 0;
    int errs = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mbox_channel dut (
        .clk(clk), .rst_n(rst_n),
        .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_sci(h_sci), .h_smi(h_smi),
        .c_addr(c_addr), .c_wr(c_wr), .c_rd(c_rd), .c_wdata(c_wdata),
        .c_rdata(c_rdata), .c_irq(c_irq)
    );

    // behavioural reference
    bit m_obf, m_ibf, m_a2, m_f0, m_ien, m_sci, m_smi;
    bit [3:0] m_st;
    bit [7:0] m_din, m_dout;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_status();
        return {m_st, m_a2, m_f0, m_ibf, m_obf};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_obf, m_ibf, m_a2, m_f0, m_ien, m_sci, m_smi} <= '0;
            m_st <= '0; m_din <= '0; m_dout <= '0;
        end else begin
            automatic bit hw  = h_wr && (h_addr == 0 || h_addr == 4);
            automatic bit hr  = h_rd && h_addr == 0;
            automatic bit cwl = c_wr && (c_addr >= 1 && c_addr <= 3);
            automatic bit crd = c_rd && (c_addr == 4 || c_addr == 5);
            if (hw) begin m_din <= h_wdata; m_a2 <= (h_addr == 4); end
            m_ibf <= hw ? 1'b1 : (crd ? 1'b0 : m_ibf);
            if (cwl) m_dout <= c_wdata;
            m_obf <= cwl ? 1'b1 : (hr ? 1'b0 : m_obf);
            if (c_wr && c_addr == 0) begin m_f0 <= c_wdata[2]; m_st <= c_wdata[7:4]; end
            if (c_wr && c_addr == 6) m_ien <= c_wdata[0];
            m_sci <= c_wr && c_addr == 2;
            m_smi <= c_wr && c_addr == 3;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            automatic int eh = (h_addr == 0) ? int'(m_dout) : (h_addr == 4) ? exp_status() : 0;
            automatic int ec = (c_addr == 0) ? exp_status() :
                               (c_addr == 4 || c_addr == 5) ? int'(m_din) :
                               (c_addr == 6) ? int'(m_ien) : 0;
            chk("MODEL h_rdata", h_rdata, eh);
            chk("MODEL c_rdata", c_rdata, ec);
            chk("MODEL c_irq", c_irq, m_ibf && m_ien);
            chk("MODEL h_sci", h_sci, m_sci);
            chk("MODEL h_smi", h_smi, m_smi);
        end
    end

    // one clock edge, then strobes back to idle
    task automatic step();
        @(negedge clk); #1;
        h_wr = 0; h_rd = 0; c_wr = 0; c_rd = 0;
    endtask

    task automatic hpeek(input logic [2:0] a, output logic [7:0] v);
        h_addr = a; #1; v = h_rdata;
    endtask

    task automatic cpeek(input logic [2:0] a, output logic [7:0] v);
        c_addr = a; #1; v = c_rdata;
    endtask

    task automatic host_w(input logic [2:0] a, input logic [7:0] d);
        h_addr = a; h_wdata = d; h_wr = 1; step();
    endtask

    task automatic core_w(input logic [2:0] a, input logic [7:0] d);
        c_addr = a; c_wdata = d; c_wr = 1; step();
    endtask

    initial begin
        #(200000 * 10);
        errs++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        step();

        // R1 reset state
        hpeek(4, v); chk("R1 status", v, 8'h00);
        chk("R1 irq", c_irq, 0);
        chk("R1 sci", h_sci, 0);
        chk("R1 smi", h_smi, 0);
        cpeek(6, v); chk("R1 ien", v, 0);

        // R8 enable, R4/R5 data write
        core_w(6, 8'h01);
        host_w(0, 8'h11);
        hpeek(4, v); chk("R4 R5 status after data write", v, 8'h02);
        chk("R8 irq when full and enabled", c_irq, 1);

        // R9 overwrite while full via command port
        host_w(4, 8'h22);
        hpeek(4, v); chk("R9 R5 status after cmd write", v, 8'h0A);
        cpeek(4, v); chk("R9 overwritten byte", v, 8'h22);
        cpeek(5, v); chk("R4 alt read register", v, 8'h22);
        c_addr = 5; c_rd = 1; step();
        hpeek(4, v); chk("R4 R5 drain keeps A2", v, 8'h08);
        chk("R8 irq drops after read", c_irq, 0);

        // R6 status write ignores read-only bits
        core_w(0, 8'hFF);
        hpeek(4, v); chk("R6 status after all-ones write", v, 8'hFC);
        cpeek(0, v); chk("R2 core status view", v, 8'hFC);
        core_w(0, 8'h50);
        hpeek(4, v); chk("R6 R2 ST0 ST2 only", v, 8'h58);

        // R7 SCI variant, R3 output path
        core_w(2, 8'h5A);
        chk("R7 sci high", h_sci, 1);
        chk("R7 smi low on sci write", h_smi, 0);
        hpeek(4, v); chk("R3 obf set", v[0], 1);
        hpeek(0, v); chk("R3 data byte", v, 8'h5A);
        h_addr = 0; h_rd = 1; step();
        chk("R7 sci one cycle", h_sci, 0);
        hpeek(4, v); chk("R3 obf cleared", v[0], 0);

        // R7 SMI variant and plain variant
        core_w(3, 8'hA5);
        chk("R7 smi high", h_smi, 1);
        chk("R7 sci low on smi write", h_sci, 0);
        core_w(1, 8'h33);
        chk("R7 plain no smi", h_smi, 0);
        chk("R7 plain no sci", h_sci, 0);
        hpeek(0, v); chk("R3 plain load", v, 8'h33);

        // R3 collision: load and host read in same cycle
        h_addr = 0; h_rd = 1; c_addr = 1; c_wdata = 8'h44; c_wr = 1; step();
        hpeek(4, v); chk("R3 load beats drain", v[0], 1);
        hpeek(0, v); chk("R3 new byte after collision", v, 8'h44);

        // R10 ignored host offsets
        hpeek(4, v);
        host_w(2, 8'h99);
        hpeek(4, v); chk("R10 write at offset 2 ignored", v, 8'h59);
        cpeek(4, v); chk("R10 input buffer untouched", v, 8'h22);
        hpeek(1, v); chk("R10 read at offset 1", v, 8'h00);
        cpeek(7, v); chk("R10 core unused offset", v, 8'h00);

        // R4 collision: host write and core read same cycle
        host_w(0, 8'h66);
        h_addr = 0; h_wdata = 8'h77; h_wr = 1; c_addr = 4; c_rd = 1; step();
        hpeek(4, v); chk("R4 write beats drain", v[1], 1);
        cpeek(4, v); chk("R4 R9 latest byte", v, 8'h77);
        hpeek(4, v); chk("R5 A2 data port", v[3], 0);

        // R8 enable gating
        core_w(6, 8'h00);
        chk("R8 irq gated off", c_irq, 0);
        core_w(6, 8'h01);
        chk("R8 irq re-enabled", c_irq, 1);

        step(); step();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule